// File: doc/BRIEF.md
# Width-Expanding Dual-Clock Lane FIFO

This block moves data for one byte group from a fast PHY capture clock domain into a slower fabric clock domain. Each PHY-side write carries a 4-bit nibble on each of ten lanes. Two writes in a row are paired into one wide word that carries an 8-bit byte per lane. Because of this pairing, the fabric side can run at half the PHY word rate.

The storage holds eight wide words. The write pointer and the read pointer cross between the two domains in Gray code through two-flop synchronizers. Each side has its own occupancy flags: full and almost-full on the write clock, empty and almost-empty on the read clock. The read side is first-word fall-through: the oldest word sits on the read data port whenever the FIFO is not empty, and a read pops it.

Top module: `lane_fifo_x2`

## Requirements
- R1: While reset is low, and right after it is released, empty and aempty are 1 and full and afull are 0.
- R2: Input lane i uses wdata bits 4i+3:4i. Output lane i uses rdata bits 8i+7:8i. Within an output lane, the nibble from the first write of a pair forms bits 3:0 and the nibble from the second write forms bits 7:4.
- R3: A wide word becomes readable only after both of its halves have been written. A single half leaves empty at 1.
- R4: Words leave in the order they were completed. Up to eight words are held, and rdata shows the oldest word whenever empty is 0.
- R5: full is 1 when eight words are stored. afull is 1 when seven or more words are stored.
- R6: empty is 1 when no word is readable. aempty is 1 when one word or none is readable.
- R7: A write, of either half, is ignored while full is 1 and does not disturb the stored words or the pairing.
- R8: A read while empty is 1 is ignored and does not move the read pointer.
- R9: Reset discards the stored words and any half-filled word, so the first write after reset is again a first half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | PHY-side write clock |
| rclk | input | 1 | Fabric-side read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Write one half-word |
| wdata | input | 40 | Ten lanes of 4-bit data |
| full | output | 1 | Eight words stored (write clock) |
| afull | output | 1 | Seven or more words stored (write clock) |
| rd_en | input | 1 | Pop the word on rdata |
| rdata | output | 80 | Ten lanes of 8-bit data, the oldest word |
| empty | output | 1 | No word readable (read clock) |
| aempty | output | 1 | One word or none readable (read clock) |

## Verification
The assertions assume that reset covers both clock domains together and that wr_en and rd_en are synchronous to their own clocks. The bench drives each enable only at the falling edge of its own clock, and it releases reset with both clocks running. The checks on held pointers and held read data also assume the environment never writes while full or reads while empty. The bench does make such requests on purpose, but only at moments when the flags are settled, so the ignored requests exercise the guard logic and cannot race a pointer update.

// File: rtl/lane_fifo_x2.sv
module lane_fifo_x2 #(
  parameter int LANES = 10,
  parameter int NIB   = 4,
  parameter int DEPTH = 8
) (
  input  logic                     wclk,
  input  logic                     rclk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [LANES*NIB-1:0]     wdata,
  output logic                     full,
  output logic                     afull,
  input  logic                     rd_en,
  output logic [LANES*2*NIB-1:0]   rdata,
  output logic                     empty,
  output logic                     aempty
);
  localparam int IW = LANES * NIB;
  localparam int OW = 2 * IW;
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] NFULL = (AW+1)'(DEPTH);
  localparam logic [AW:0] NONE  = (AW+1)'(1);

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [OW-1:0] mem [DEPTH];
  logic [IW-1:0] lo_q;
  logic          phase;
  logic [AW:0]   wbin, wgray, rbin, rgray;
  logic [AW:0]   rq1, rq2, wq1, wq2;
  logic [OW-1:0] pair;
  logic [AW:0]   wcount, rcount;

  wire wr_ok = wr_en && !full;
  wire rd_ok = rd_en && !empty;

  always_comb
    for (int l = 0; l < LANES; l++)
      pair[l*2*NIB +: 2*NIB] = {wdata[l*NIB +: NIB], lo_q[l*NIB +: NIB]};

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      phase <= 1'b0;
      lo_q  <= '0;
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_ok) begin
      phase <= ~phase;
      if (!phase) lo_q <= wdata;
      else begin
        wbin  <= wbin + 1'b1;
        wgray <= (wbin + 1'b1) ^ ((wbin + 1'b1) >> 1);
      end
    end

  always_ff @(posedge wclk)
    if (wr_ok && phase) mem[wbin[AW-1:0]] <= pair;

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (rd_ok) begin
      rbin  <= rbin + 1'b1;
      rgray <= (rbin + 1'b1) ^ ((rbin + 1'b1) >> 1);
    end

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) {rq2, rq1} <= '0;
    else        {rq2, rq1} <= {rq1, rgray};

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) {wq2, wq1} <= '0;
    else        {wq2, wq1} <= {wq1, wgray};

  assign wcount = wbin - g2b(rq2);
  assign rcount = g2b(wq2) - rbin;
  assign full   = (wcount == NFULL);
  assign afull  = (wcount >= NFULL - NONE);
  assign empty  = (rcount == '0);
  assign aempty = (rcount <= NONE);
  assign rdata  = mem[rbin[AW-1:0]];
endmodule

// File: rtl/lane_fifo_x2_chk.sv
module lane_fifo_x2_chk #(
  parameter int AW = 3,
  parameter int OW = 80
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          full,
  input logic          afull,
  input logic          empty,
  input logic          aempty,
  input logic [AW:0]   wbin,
  input logic [AW:0]   rbin,
  input logic [OW-1:0] rdata
);
  a_r5_full_has_afull: assert property (@(posedge wclk) disable iff (!rst_n)
    full |-> afull);

  a_r6_empty_has_aempty: assert property (@(posedge rclk) disable iff (!rst_n)
    empty |-> aempty);

  a_r7_no_overflow: assert property (@(posedge wclk) disable iff (!rst_n)
    (wr_en && full) |=> $stable(wbin));

  a_r8_no_underflow: assert property (@(posedge rclk) disable iff (!rst_n)
    (rd_en && empty) |=> $stable(rbin));

  a_r4_head_held: assert property (@(posedge rclk) disable iff (!rst_n)
    (!empty && !rd_en) |=> $stable(rdata));
endmodule

bind lane_fifo_x2 lane_fifo_x2_chk #(.AW(AW), .OW(OW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
  .full(full), .afull(afull), .empty(empty), .aempty(aempty),
  .wbin(wbin), .rbin(rbin), .rdata(rdata));

// File: tb/tb_lane_fifo_x2.sv
module tb_lane_fifo_x2;
  logic        wclk = 0, rclk = 0, rst_n = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [39:0] wdata = '0;
  logic [79:0] rdata;
  logic        full, afull, empty, aempty;
  int          n_chk = 0, n_bad = 0, wd = 0;

  lane_fifo_x2 dut (.wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en(wr_en),
    .wdata(wdata), .full(full), .afull(afull), .rd_en(rd_en), .rdata(rdata),
    .empty(empty), .aempty(aempty));

  always #4 wclk = ~wclk;
  always #6 rclk = ~rclk;

  localparam logic [39:0] VLO [8] = '{40'h0123456789, 40'hFEDCBA9876, 40'h0000000000,
    40'hFFFFFFFFFF, 40'h5A5A5A5A5A, 40'h13579BDF02, 40'h8421084210, 40'hC3C3C3C3C3};
  localparam logic [39:0] VHI [8] = '{40'h9876543210, 40'h0F1E2D3C4B, 40'hFFFFFFFFFF,
    40'h0000000000, 40'hA5A5A5A5A5, 40'h2468ACE135, 40'h1248124812, 40'h3C3C3C3C3C};

  function automatic logic [79:0] expw(input logic [39:0] lo, input logic [39:0] hi);
    logic [79:0] r;
    for (int l = 0; l < 10; l++) begin
      r[8*l +: 4]   = lo[4*l +: 4];
      r[8*l+4 +: 4] = hi[4*l +: 4];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [39:0] d);
    @(negedge wclk); wr_en = 1; wdata = d;
    @(negedge wclk); wr_en = 0;
  endtask

  task automatic get(input string req, input logic [79:0] exp);
    @(negedge rclk);
    chk(req, {79'd0, empty}, 80'd0);
    chk(req, rdata, exp);
    rd_en = 1;
    @(negedge rclk); rd_en = 0;
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
    repeat (2) @(negedge wclk);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge wclk) begin
    wd++;
    if (wd > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<100000", wd);
      report();
    end
  end

  initial begin
    // R1: flags during and after reset
    repeat (3) @(negedge wclk);
    chk("R1", {76'd0, empty, aempty, full, afull}, 80'b1100);
    rst_n = 1;
    settle();
    chk("R1", {76'd0, empty, aempty, full, afull}, 80'b1100);

    // R3: a lone half stays invisible
    put(VLO[0]); settle();
    chk("R3", {79'd0, empty}, 80'd1);
    put(VHI[0]); settle();
    chk("R3", {79'd0, empty}, 80'd0);
    chk("R6", {79'd0, aempty}, 80'd1);
    chk("R2", rdata, expw(VLO[0], VHI[0]));

    // R5: walk the vector table to fill the FIFO
    for (int i = 1; i < 8; i++) begin
      put(VLO[i]); put(VHI[i]);
      if (i == 1) begin settle(); chk("R6", {79'd0, aempty}, 80'd0); end
      if (i == 6) chk("R5", {78'd0, full, afull}, 80'b01);
    end
    chk("R5", {78'd0, full, afull}, 80'b11);

    // R7: writes while full are dropped
    put(40'hAAAAAAAAAA); put(40'h5555555555);
    chk("R7", {79'd0, full}, 80'd1);
    settle();

    // R4/R2: drain in order
    for (int i = 0; i < 8; i++) get("R4", expw(VLO[i], VHI[i]));
    settle();
    chk("R6", {78'd0, empty, aempty}, 80'b11);
    chk("R5", {78'd0, full, afull}, 80'b00);

    // R8: read while empty is ignored
    @(negedge rclk); rd_en = 1; @(negedge rclk); rd_en = 0;
    put(VLO[4]); put(VHI[4]); settle();
    get("R8", expw(VLO[4], VHI[4]));
    settle();
    chk("R8", {79'd0, empty}, 80'd1);

    // R9: reset drops a half-filled word
    put(VLO[3]);
    @(negedge wclk); rst_n = 0;
    repeat (2) @(negedge wclk);
    chk("R1", {76'd0, empty, aempty, full, afull}, 80'b1100);
    rst_n = 1; settle();
    put(VLO[5]); put(VHI[5]); settle();
    get("R9", expw(VLO[5], VHI[5]));
    report();
  end
endmodule